// File: doc/BRIEF.md
# Video Address Space Mirroring Decoder

This block sits between the video-side address bus of a tile-based picture unit and its physical storage. The storage consists of pattern memory, two 1 KB nametable pages and a 32-byte palette store. For each access cycle it tells the storage which target to enable, the physical index inside that target, and whether the cycle may write. Four logical nametables share the two physical pages. A configuration input chooses which pairs of them alias. The region above the nametables repeats them, and the palette store repeats every 32 bytes up to the top of the space.

The decoder takes an address with a read strobe and a write strobe. It also takes the nametable fold setting and a flag that tells whether pattern memory is writable RAM or read-only ROM. All outputs are registered, so the select, index and write enable for an access appear on the clock edge after the strobe is sampled. Only the low 14 address bits are decoded, so the space repeats every 16 KB.

Top module: `vaddr_mirror_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sel_o` is 0, `idx_o` is 0 and `we_o` is 0.
- R2: A cycle with neither `rd_en` nor `wr_en` gives `sel_o` = 0 (no target), `idx_o` = 0 and `we_o` = 0 on the next cycle.
- R3: An access with folded address (bits 13:0) in 0x0000–0x1FFF gives `sel_o` = 1 (pattern) and `idx_o` = address bits 12:0 on the next cycle.
- R4: A pattern write sets `we_o` only when `pat_is_ram` is 1. With `pat_is_ram` at 0 the write is dropped: `we_o` stays 0 while `sel_o` still shows 1.
- R5: With `nt_fold_h` = 1, an access in 0x2000–0x3EFF gives `sel_o` = 2 (nametable) and `idx_o` = {address bit 10, address bits 9:0}. This maps 0x2000/0x2800 to page 0 and 0x2400/0x2C00 to page 1.
- R6: With `nt_fold_h` = 0, the same accesses give `idx_o` = {address bit 11, address bits 9:0}. This maps 0x2000/0x2400 to page 0 and 0x2800/0x2C00 to page 1.
- R7: An address in 0x3000–0x3EFF decodes exactly as that address minus 0x1000.
- R8: An access in 0x3F00–0x3FFF gives `sel_o` = 3 (palette) and `idx_o` = address bits 4:0. The 32-byte store therefore repeats every 32 bytes.
- R9: Address bits 15:14 have no effect on any output.
- R10: A write to a nametable or palette address sets `we_o` on the next cycle. A read never sets `we_o`.
- R11: When both strobes are high in one cycle, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 16 | Video bus address; bits above 13 are ignored |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| nt_fold_h | input | 1 | Nametable fold select: 1 pairs by bit 11, 0 pairs by bit 10 |
| pat_is_ram | input | 1 | 1 when pattern memory is writable RAM, 0 when ROM |
| sel_o | output | 2 | Target: 0 none, 1 pattern, 2 nametable, 3 palette |
| idx_o | output | 13 | Physical index within the selected target |
| we_o | output | 1 | Write enable for the selected target |

## Verification
The assertions compare each output to the inputs of the previous cycle and assume nothing more about those inputs. Any mix of strobes, fold setting and pattern type is legal on any cycle, including both strobes together. The stimulus therefore changes the fold setting and the pattern RAM/ROM flag cycle by cycle. It mixes directed addresses at each region edge and at each alias of the four nametables with random 16-bit addresses that set the upper bits. A reference model built from address arithmetic predicts every output and is compared on every cycle.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PAT  = 2'd1,
    SEL_NT   = 2'd2,
    SEL_PAL  = 2'd3
  } store_sel_e;
endpackage

// File: rtl/vdec_region.sv
module vdec_region
  import vdec_pkg::*;
#(
  parameter int SPACE_W = 14,
  parameter int PAL_SPAN_W = 8
) (
  input  logic [SPACE_W-1:0] addr,
  output store_sel_e         region
);
  localparam int HI_W = SPACE_W - PAL_SPAN_W;

  logic pal_hit;
  assign pal_hit = &addr[SPACE_W-1:PAL_SPAN_W];

  always_comb begin
    if (!addr[SPACE_W-1])
      region = SEL_PAT;
    else if (pal_hit)
      region = SEL_PAL;
    else
      region = SEL_NT;
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr[SPACE_W-1:PAL_SPAN_W];
endmodule

// File: rtl/vdec_nt_fold.sv
module vdec_nt_fold #(
  parameter int PAGE_W = 10
) (
  input  logic [PAGE_W+1:0] off,
  input  logic              fold_h,
  output logic [PAGE_W:0]   phys
);
  logic page_bit;
  assign page_bit = fold_h ? off[PAGE_W] : off[PAGE_W+1];
  assign phys     = {page_bit, off[PAGE_W-1:0]};
endmodule

// File: rtl/vdec_out_reg.sv
module vdec_out_reg
  import vdec_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  store_sel_e       sel_d,
  input  logic [IDX_W-1:0] idx_d,
  input  logic             we_d,
  output store_sel_e       sel_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_NONE;
      idx_q <= '0;
      we_q  <= 1'b0;
    end else if (acc) begin
      sel_q <= sel_d;
      idx_q <= idx_d;
      we_q  <= we_d;
    end else begin
      sel_q <= SEL_NONE;
      idx_q <= '0;
      we_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/vaddr_mirror_decoder.sv
module vaddr_mirror_decoder
  import vdec_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int SPACE_W    = 14,
  parameter int PAT_W      = 13,
  parameter int PAGE_W     = 10,
  parameter int PAL_W      = 5,
  parameter int PAL_SPAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              nt_fold_h,
  input  logic              pat_is_ram,
  output logic [1:0]        sel_o,
  output logic [PAT_W-1:0]  idx_o,
  output logic              we_o
);
  localparam int IDX_W = PAT_W;
  localparam int NT_W  = PAGE_W + 1;

  logic [SPACE_W-1:0] fold_addr;

  generate
    if (VA_W > SPACE_W) begin : g_wrap
      logic [VA_W-SPACE_W-1:0] dropped;
      assign dropped   = vaddr[VA_W-1:SPACE_W];
      assign fold_addr = vaddr[SPACE_W-1:0];
    end else begin : g_exact
      assign fold_addr = SPACE_W'(vaddr);
    end
  endgenerate

  store_sel_e region;
  vdec_region #(.SPACE_W(SPACE_W), .PAL_SPAN_W(PAL_SPAN_W)) u_region (
    .addr   (fold_addr),
    .region (region)
  );

  logic [NT_W-1:0] nt_phys;
  vdec_nt_fold #(.PAGE_W(PAGE_W)) u_fold (
    .off    (fold_addr[PAGE_W+1:0]),
    .fold_h (nt_fold_h),
    .phys   (nt_phys)
  );

  logic [IDX_W-1:0] idx_d;
  logic             we_d;
  logic             acc;

  assign acc = rd_en | wr_en;

  always_comb begin
    unique case (region)
      SEL_PAT: idx_d = fold_addr[PAT_W-1:0];
      SEL_NT:  idx_d = IDX_W'(nt_phys);
      SEL_PAL: idx_d = IDX_W'(fold_addr[PAL_W-1:0]);
      default: idx_d = '0;
    endcase
  end

  assign we_d = wr_en & ((region != SEL_PAT) | pat_is_ram);

  store_sel_e sel_q;
  vdec_out_reg #(.IDX_W(IDX_W)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .sel_d (region),
    .idx_d (idx_d),
    .we_d  (we_d),
    .sel_q (sel_q),
    .idx_q (idx_o),
    .we_q  (we_o)
  );

  assign sel_o = sel_q;
endmodule

// File: rtl/vdec_checker.sv
module vdec_checker #(
  parameter int VA_W       = 16,
  parameter int SPACE_W    = 14,
  parameter int PAT_W      = 13,
  parameter int PAGE_W     = 10,
  parameter int PAL_W      = 5,
  parameter int PAL_SPAN_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [VA_W-1:0]   vaddr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              nt_fold_h,
  input logic              pat_is_ram,
  input logic [1:0]        sel_o,
  input logic [PAT_W-1:0]  idx_o,
  input logic              we_o
);
  logic acc, pat_hit, pal_hit, nt_hit;
  assign acc     = rd_en | wr_en;
  assign pat_hit = !vaddr[SPACE_W-1];
  assign pal_hit = &vaddr[SPACE_W-1:PAL_SPAN_W];
  assign nt_hit  = vaddr[SPACE_W-1] && !pal_hit;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> (sel_o == 2'd0 && !we_o && idx_o == '0)); // R2

  AST_PAT_INDEX: assert property (@(posedge clk) disable iff (rst)
    (acc && pat_hit) |=> (sel_o == 2'd1 && idx_o == $past(vaddr[PAT_W-1:0]))); // R3

  AST_ROM_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pat_hit && !pat_is_ram) |=> !we_o); // R4

  AST_NT_PAIR_H: assert property (@(posedge clk) disable iff (rst)
    (acc && nt_hit && nt_fold_h) |=>
      (sel_o == 2'd2 && idx_o[PAGE_W] == $past(vaddr[PAGE_W]))); // R5

  AST_NT_PAIR_V: assert property (@(posedge clk) disable iff (rst)
    (acc && nt_hit && !nt_fold_h) |=>
      (sel_o == 2'd2 && idx_o[PAGE_W] == $past(vaddr[PAGE_W+1]))); // R6

  AST_PAL_MAP: assert property (@(posedge clk) disable iff (rst)
    (acc && pal_hit) |=>
      (sel_o == 2'd3 && idx_o == {{(PAT_W-PAL_W){1'b0}}, $past(vaddr[PAL_W-1:0])})); // R8

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !we_o); // R10

  AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && !pat_hit) |=> we_o); // R11
endmodule

bind vaddr_mirror_decoder vdec_checker #(
  .VA_W(VA_W), .SPACE_W(SPACE_W), .PAT_W(PAT_W),
  .PAGE_W(PAGE_W), .PAL_W(PAL_W), .PAL_SPAN_W(PAL_SPAN_W)
) u_chk (
  .clk(clk), .rst(rst), .vaddr(vaddr), .rd_en(rd_en), .wr_en(wr_en),
  .nt_fold_h(nt_fold_h), .pat_is_ram(pat_is_ram),
  .sel_o(sel_o), .idx_o(idx_o), .we_o(we_o)
);

// File: tb/vaddr_mirror_decoder_tb.sv
`timescale 1ns/1ps
module vaddr_mirror_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] vaddr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, nt_fold_h = 1'b0, pat_is_ram = 1'b0;
  logic [1:0]  sel_o;
  logic [12:0] idx_o;
  logic        we_o;

  int total = 0;
  int bad   = 0;

  int    q_sel[$];
  int    q_idx[$];
  int    q_we[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  vaddr_mirror_decoder dut_i (
    .clk(clk), .rst(rst), .vaddr(vaddr), .rd_en(rd_en), .wr_en(wr_en),
    .nt_fold_h(nt_fold_h), .pat_is_ram(pat_is_ram),
    .sel_o(sel_o), .idx_o(idx_o), .we_o(we_o)
  );

  function automatic void model(input int a_in, input bit rd, input bit wr,
                                input bit fh, input bit ram,
                                output int s, output int ix, output int w,
                                output string tag);
    int a, n, t, pg;
    a = a_in % 16384;
    s = 0; ix = 0; w = 0; tag = "R2";
    if (!rd && !wr) return;
    if (a < 8192) begin
      s = 1; ix = a; w = (wr && ram) ? 1 : 0;
      tag = wr ? "R4" : "R3";
    end else if (a >= 16128) begin
      s = 3; ix = a % 32; w = wr ? 1 : 0;
      tag = wr ? "R10" : "R8";
    end else begin
      n  = (a - 8192) % 4096;
      t  = n / 1024;
      pg = fh ? (t % 2) : (t / 2);
      s = 2; ix = pg * 1024 + n % 1024; w = wr ? 1 : 0;
      if (wr) tag = "R10";
      else if (a >= 12288) tag = "R7";
      else tag = fh ? "R5" : "R6";
    end
    if (rd && wr) tag = "R11";
    else if (a_in >= 16384) tag = "R9";
  endfunction

  task automatic check(input int got, input int exp, input string tag, input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input int a, input bit rd, input bit wr, input bit fh, input bit ram);
    int s, ix, w;
    string tag;
    vaddr = a[15:0]; rd_en = rd; wr_en = wr; nt_fold_h = fh; pat_is_ram = ram;
    model(a, rd, wr, fh, ram, s, ix, w, tag);
    q_sel.push_back(s); q_idx.push_back(ix); q_we.push_back(w); q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    begin
      int es, ei, ew;
      string et;
      es = q_sel.pop_front(); ei = q_idx.pop_front();
      ew = q_we.pop_front();  et = q_tag.pop_front();
      check(int'(sel_o), es, et, "sel");
      check(int'(idx_o), ei, et, "idx");
      check(int'(we_o),  ew, et, "we");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(sel_o), 0, "R1", "reset sel");
    check(int'(idx_o), 0, "R1", "reset idx");
    check(int'(we_o),  0, "R1", "reset we");
    rst = 1'b0;
    @(negedge clk);
    check(int'(sel_o), 0, "R1", "post-reset sel");

    // R3 / R4 pattern region edges, ROM and RAM
    cyc('h0000, 1, 0, 0, 0);
    cyc('h1FFF, 1, 0, 1, 0);
    cyc('h0ABC, 0, 1, 0, 0);
    cyc('h1234, 0, 1, 0, 1);
    // R2 idle
    cyc('h2345, 0, 0, 1, 1);
    // R5 horizontal pairing: every nametable base
    for (int k = 0; k < 4; k++) cyc('h2000 + k * 'h400 + 'h155, 1, 0, 1, 0);
    // R6 vertical pairing
    for (int k = 0; k < 4; k++) cyc('h2000 + k * 'h400 + 'h2AA, 1, 0, 0, 0);
    // R7 upper mirror region, both foldings, edge at 0x3EFF
    cyc('h3000, 1, 0, 1, 0);
    cyc('h3EFF, 1, 0, 0, 0);
    cyc('h3C10, 1, 0, 1, 0);
    // R8 palette and its repeats
    cyc('h3F00, 1, 0, 0, 0);
    cyc('h3F1F, 1, 0, 0, 0);
    cyc('h3F20, 1, 0, 1, 0);
    cyc('h3FFF, 1, 0, 1, 0);
    // R10 writes to RAM pages
    cyc('h2C01, 0, 1, 0, 0);
    cyc('h3F05, 0, 1, 1, 0);
    // R11 both strobes
    cyc('h2401, 1, 1, 1, 0);
    cyc('h0400, 1, 1, 0, 0);
    cyc('h0400, 1, 1, 0, 1);
    // R9 upper bits ignored
    cyc('hC000 | 'h3F07, 1, 0, 0, 0);
    cyc('h4000 | 'h2C33, 1, 0, 1, 0);
    cyc('h8000 | 'h0777, 0, 1, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom);
      cyc(r & 'hFFFF, r[16], r[17], r[18], r[19]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule